// File: doc/BRIEF.md
# Three-Wire Serial Byte Shifter

This block moves one byte at a time over a three-wire serial link: a serial data output, a serial data input and a serial clock. A shift register sends its most significant bit first and takes received bits in at the least significant end, so after one full byte the register holds the byte that came in. An edge counter counts every serial clock edge, both rising and falling, and raises a completion flag when a byte has finished. That flag can also drive an interrupt line.

The serial clock comes from one of two sources. An external clock pin can drive it, and that pin is synchronized into the system clock domain. The host can also make the clock itself: each write of a one to a toggle control bit inverts the block's clock output, and the shifter treats that inversion as a serial edge. A host port gives write and combinational read access to the data register, a control register and a status register. A control bit chooses which edge samples the input and which edge shifts.

Top module: `tri_wire_shifter`

## Requirements
- R1: After reset the data, control and status registers read zero, and sclk_out, sdo and irq are low.
- R2: With control bit 0 clear, a rising serial edge latches sdi and a falling edge shifts the data register left by one, with the latched bit entering bit 0. sdo always shows bit 7 of the data register.
- R3: With control bit 0 set, the edge roles swap. A falling edge latches sdi and a rising edge shifts.
- R4: Each serial edge advances the 4-bit counter (status bits 3:0). The 16th edge wraps the counter from 15 to 0 and sets the completion flag (status bit 7).
- R5: Writing the control register (address 1) with bit 2 set inverts sclk_out. When the written bit 1 selects the software source, that inversion is a serial edge whose direction follows the new level of sclk_out. The edge uses the control bits written in that same write. Bit 2 always reads back as 0.
- R6: With control bit 1 clear, a level change on sclk_in acts on the second system clock edge after it is captured. With control bit 1 set, sclk_in is ignored.
- R7: Writing the status register (address 2) with bit 7 set clears the flag and the counter. Writing it with bit 7 clear changes nothing.
- R8: irq is high exactly when the completion flag is set and control bit 3 is set.
- R9: A host write to the data register (address 0) or a clearing status write takes precedence over a serial edge in the same cycle. A data write does not stop that edge from advancing the counter.
- R10: Reads return the data register at address 0, control bits 3, 1 and 0 at address 1, the status register at address 2, and zero at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write register select |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 2 | Host read register select |
| rd_data | output | 8 | Host read data (combinational) |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Software-generated serial clock line |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output (register MSB) |
| irq | output | 1 | Byte-complete interrupt request |

## Verification
On every cycle, the assertions check how the counter and flag respond to an edge or a clearing write. They also check that the counter, the flag and the data register hold when nothing acts on them, that a data load takes effect, that the clock line follows toggle writes, and that irq never rises without the flag. Several behaviours can only be shown by the bench's scenarios against its reference model: the bit order of a full byte in both edge-select settings, the two-cycle latency and masking of the external clock, the precedence of host writes over a coinciding external edge, and the register read map.

// File: rtl/tws_pkg.sv
`timescale 1ns/1ps
package tws_pkg;

   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_DATA = 2'd0,
      REG_CTRL = 2'd1,
      REG_STAT = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   localparam int CTL_EDGE = 0;
   localparam int CTL_SRC  = 1;
   localparam int CTL_TGL  = 2;
   localparam int CTL_IRQ  = 3;

   typedef struct packed {
      logic irq_en;
      logic sw_src;
      logic edge_swap;
   } ctrl_t;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;

endpackage

// File: rtl/tws_clk_sync.sv
`timescale 1ns/1ps
module tws_clk_sync
   import tws_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sclk_in,
   output edge_t ext_edge
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], sclk_in};
      end
   end

   // compare the two oldest stages to find a settled level change
   always_comb begin
      ext_edge.rise = chain[STAGES-2] & ~chain[STAGES-1];
      ext_edge.fall = ~chain[STAGES-2] & chain[STAGES-1];
   end

endmodule

// File: rtl/tws_edge_gen.sv
`timescale 1ns/1ps
module tws_edge_gen
   import tws_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit EXT_CLK_EN  = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sclk_in,
   input  logic  toggle_wr,
   input  logic  sw_src,
   output logic  sclk_line,
   output edge_t ser_edge,
   output logic  edge_any
);

   edge_t ext_edge;
   edge_t sw_edge;
   logic  line_q;

   generate
      if (EXT_CLK_EN) begin : g_ext
         tws_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .sclk_in  (sclk_in),
            .ext_edge (ext_edge)
         );
      end else begin : g_no_ext
         assign ext_edge = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
      end else if (toggle_wr) begin
         line_q <= ~line_q;
      end
   end

   always_comb begin
      sw_edge.rise = toggle_wr & ~line_q;
      sw_edge.fall = toggle_wr & line_q;
      ser_edge     = sw_src ? sw_edge : ext_edge;
      edge_any     = ser_edge.rise | ser_edge.fall;
   end

   assign sclk_line = line_q;

endmodule

// File: rtl/tws_shift_core.sv
`timescale 1ns/1ps
module tws_shift_core
   import tws_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(2 * DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  edge_t             ser_edge,
   input  logic              edge_swap,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_val,
   input  logic              clr_en,
   input  logic              sdi,
   output logic [DATA_W-1:0] data_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              ovf_q,
   output logic              shift_ev
);

   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * DATA_W - 1);

   logic sample_ev;
   logic edge_ev;
   logic smp_q;

   always_comb begin
      sample_ev = edge_swap ? ser_edge.fall : ser_edge.rise;
      shift_ev  = edge_swap ? ser_edge.rise : ser_edge.fall;
      edge_ev   = ser_edge.rise | ser_edge.fall;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q <= 1'b0;
      end else if (sample_ev) begin
         smp_q <= sdi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (load_en) begin
         data_q <= load_val;
      end else if (shift_ev) begin
         data_q <= {data_q[DATA_W-2:0], smp_q};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (clr_en) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (edge_ev) begin
         if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            ovf_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tri_wire_shifter.sv
`timescale 1ns/1ps
module tri_wire_shifter
   import tws_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit EXT_CLK_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              sclk_in,
   output logic              sclk_out,
   input  logic              sdi,
   output logic              sdo,
   output logic              irq
);

   localparam int CNT_W = $clog2(2 * DATA_W);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("tri_wire_shifter: DATA_W must be at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tri_wire_shifter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   ctrl_t             ctrl_q;
   ctrl_t             ctrl_nx;
   logic              wr_ctrl;
   logic              toggle_wr;
   logic              load_en;
   logic              clr_en;
   logic              irq_en_q;
   edge_t             ser_edge;
   logic              edge_any;
   logic              shift_ev;
   logic [DATA_W-1:0] data_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              ovf_q;

   always_comb begin
      wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
      toggle_wr = wr_ctrl && wr_data[CTL_TGL];
      load_en   = wr_en && (wr_addr == REG_DATA);
      clr_en    = wr_en && (wr_addr == REG_STAT) && wr_data[DATA_W-1];
   end

   // control bits written together with a toggle already govern its edge
   always_comb begin
      ctrl_nx = ctrl_q;
      if (wr_ctrl) begin
         ctrl_nx.edge_swap = wr_data[CTL_EDGE];
         ctrl_nx.sw_src    = wr_data[CTL_SRC];
         ctrl_nx.irq_en    = wr_data[CTL_IRQ];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         ctrl_q <= ctrl_nx;
      end
   end

   assign irq_en_q = ctrl_q.irq_en;

   tws_edge_gen #(
      .SYNC_STAGES (SYNC_STAGES),
      .EXT_CLK_EN  (EXT_CLK_EN)
   ) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_in   (sclk_in),
      .toggle_wr (toggle_wr),
      .sw_src    (ctrl_nx.sw_src),
      .sclk_line (sclk_out),
      .ser_edge  (ser_edge),
      .edge_any  (edge_any)
   );

   tws_shift_core #(
      .DATA_W (DATA_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_edge  (ser_edge),
      .edge_swap (ctrl_nx.edge_swap),
      .load_en   (load_en),
      .load_val  (wr_data),
      .clr_en    (clr_en),
      .sdi       (sdi),
      .data_q    (data_q),
      .cnt_q     (cnt_q),
      .ovf_q     (ovf_q),
      .shift_ev  (shift_ev)
   );

   always_comb begin
      rd_data = '0;
      unique case (reg_sel_e'(rd_addr))
         REG_DATA: rd_data = data_q;
         REG_CTRL: begin
            rd_data[CTL_EDGE] = ctrl_q.edge_swap;
            rd_data[CTL_SRC]  = ctrl_q.sw_src;
            rd_data[CTL_IRQ]  = ctrl_q.irq_en;
         end
         REG_STAT: begin
            rd_data[DATA_W-1]  = ovf_q;
            rd_data[CNT_W-1:0] = cnt_q;
         end
         default: rd_data = '0;
      endcase
   end

   assign sdo = data_q[DATA_W-1];
   assign irq = ovf_q & irq_en_q;

endmodule

// File: rtl/tws_checker.sv
`timescale 1ns/1ps
module tws_checker #(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(2 * DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              edge_any,
   input logic              shift_ev,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              ovf_q,
   input logic [DATA_W-1:0] data_q,
   input logic              sclk_out,
   input logic              irq
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * DATA_W - 1);

   logic host_clr;
   logic host_load;
   logic host_tgl;

   always_comb begin
      host_clr  = wr_en && (wr_addr == 2'd2) && wr_data[DATA_W-1];
      host_load = wr_en && (wr_addr == 2'd0);
      host_tgl  = wr_en && (wr_addr == 2'd1) && wr_data[2];
   end

   assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_any && !host_clr && cnt_q != LAST) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   assert_cnt_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_any && !host_clr && cnt_q == LAST) |=> (cnt_q == '0 && ovf_q));

   assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_any && !host_clr) |=> ($stable(cnt_q) && $stable(ovf_q)));

   assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      host_clr |=> (cnt_q == '0 && !ovf_q));

   assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_ev && !host_load) |=> $stable(data_q));

   assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      host_load |=> (data_q == $past(wr_data)));

   assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      host_tgl |=> (sclk_out != $past(sclk_out)));

   assert_line_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !host_tgl |=> $stable(sclk_out));

   assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ovf_q);

endmodule

bind tri_wire_shifter tws_checker #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .edge_any (edge_any),
   .shift_ev (shift_ev),
   .cnt_q    (cnt_q),
   .ovf_q    (ovf_q),
   .data_q   (data_q),
   .sclk_out (sclk_out),
   .irq      (irq)
);

// File: tb/sim_tri_wire_shifter.sv
`timescale 1ns/1ps
module sim_tri_wire_shifter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       sclk_in = 1'b0;
   logic       sdi = 1'b0;
   logic       sclk_out, sdo, irq;

   int total = 0;
   int bad = 0;

   // reference state
   logic [7:0] m_data = 8'd0;
   logic       m_smp = 1'b0;
   logic [3:0] m_cnt = 4'd0;
   logic       m_ovf = 1'b0;
   logic       m_line = 1'b0;
   logic       m_swap = 1'b0;
   logic       m_sw = 1'b0;
   logic       m_ien = 1'b0;
   logic       m_ext = 1'b0;

   always #2 clk = ~clk;

   tri_wire_shifter u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .sclk_in(sclk_in), .sclk_out(sclk_out),
      .sdi(sdi), .sdo(sdo), .irq(irq)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_ctrl();
      return {4'b0, m_ien, 1'b0, m_sw, m_swap};
   endfunction

   function automatic logic [7:0] exp_stat();
      return {m_ovf, 3'b0, m_cnt};
   endfunction

   // one serial edge per R2/R3/R4
   task automatic m_edge(input logic rise);
      logic smp_ev;
      smp_ev = m_swap ? !rise : rise;
      if (smp_ev) m_smp = sdi;
      else m_data = {m_data[6:0], m_smp};
      if (m_cnt == 4'd15) begin
         m_cnt = 4'd0;
         m_ovf = 1'b1;
      end else begin
         m_cnt = m_cnt + 4'd1;
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      rd_addr = a;
      #0.2;
      v = rd_data;
   endtask

   task automatic compare_all();
      logic [7:0] v;
      rd(2'd0, v); chk(m_swap ? "R3 data register" : "R2 data register", v, m_data);
      rd(2'd1, v); chk("R10 control readback", v, exp_ctrl());
      rd(2'd2, v); chk("R4 status counter/flag", v, exp_stat());
      chk(m_swap ? "R3 sdo" : "R2 sdo", {7'b0, sdo}, {7'b0, m_data[7]});
      chk("R8 irq", {7'b0, irq}, {7'b0, m_ovf & m_ien});
      chk("R5 sclk_out", {7'b0, sclk_out}, {7'b0, m_line});
   endtask

   task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
      logic old;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      case (a)
         2'd0: m_data = d;
         2'd1: begin
            m_swap = d[0]; m_sw = d[1]; m_ien = d[3];
            if (d[2]) begin
               old = m_line;
               m_line = !old;
               if (m_sw) m_edge(!old);
            end
         end
         2'd2: if (d[7]) begin m_ovf = 1'b0; m_cnt = 4'd0; end
         default: ;
      endcase
   endtask

   task automatic toggle();
      host_wr(2'd1, {4'b0, m_ien, 1'b1, m_sw, m_swap});
   endtask

   // R6: acts on the second system edge after capture
   task automatic ext_drive(input logic v);
      @(negedge clk);
      sclk_in = v;
      @(negedge clk);
      @(negedge clk);
      if (v != m_ext && !m_sw) m_edge(v);
      m_ext = v;
   endtask

   initial begin
      #(200000 * 4);
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(2'd0, v); chk("R1 reset data", v, 8'h00);
      rd(2'd1, v); chk("R1 reset control", v, 8'h00);
      rd(2'd2, v); chk("R1 reset status", v, 8'h00);
      chk("R1 reset outputs", {5'b0, sclk_out, sdo, irq}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: software clock, mode 0, full byte
      host_wr(2'd1, 8'b0000_1010);
      host_wr(2'd0, 8'hA5);
      host_wr(2'd2, 8'h80);
      for (int i = 0; i < 8; i++) begin
         sdi = 8'h3C >> (7 - i);
         toggle(); compare_all();
         toggle(); compare_all();
      end
      rd(2'd0, v); chk("R2 received byte", v, 8'h3C);
      rd(2'd2, v); chk("R4 overflow after 16 edges", v, 8'h80);
      chk("R8 irq raised", {7'b0, irq}, 8'h01);

      // R7: writing zero to the flag bit has no effect
      host_wr(2'd2, 8'h7F);
      rd(2'd2, v); chk("R7 zero write keeps flag", v, 8'h80);
      host_wr(2'd2, 8'h80);
      rd(2'd2, v); chk("R7 one write clears", v, 8'h00);
      chk("R8 irq dropped", {7'b0, irq}, 8'h00);

      // R3: mode 1, line idles high
      host_wr(2'd1, 8'b0000_0011);
      toggle();
      host_wr(2'd2, 8'h80);
      host_wr(2'd0, 8'h5A);
      for (int i = 0; i < 8; i++) begin
         sdi = 8'hC3 >> (7 - i);
         toggle(); compare_all();
         toggle(); compare_all();
      end
      rd(2'd0, v); chk("R3 received byte", v, 8'hC3);
      rd(2'd2, v); chk("R4 overflow mode 1", v, 8'h80);
      chk("R8 irq masked", {7'b0, irq}, 8'h00);
      rd(2'd3, v); chk("R10 unused address", v, 8'h00);

      // R6: external clock, mode 0
      host_wr(2'd1, 8'b0000_0000);
      host_wr(2'd2, 8'h80);
      host_wr(2'd0, 8'h81);
      for (int i = 0; i < 8; i++) begin
         sdi = 8'h96 >> (7 - i);
         ext_drive(1'b1); compare_all();
         ext_drive(1'b0); compare_all();
      end
      rd(2'd0, v); chk("R6 external byte", v, 8'h96);
      // R6: external clock ignored in software source
      host_wr(2'd1, 8'b0000_0010);
      host_wr(2'd2, 8'h80);
      for (int i = 0; i < 4; i++) begin
         ext_drive(!m_ext);
      end
      rd(2'd2, v); chk("R6 external ignored", v, 8'h00);
      compare_all();

      // R9: host writes collide with an external edge
      host_wr(2'd1, 8'b0000_0000);
      ext_drive(1'b1);
      @(negedge clk); sclk_in = 1'b0;
      @(negedge clk); wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h3E;
      @(negedge clk); wr_en = 1'b0;
      m_edge(1'b0); m_data = 8'h3E; m_ext = 1'b0;
      rd(2'd0, v); chk("R9 load beats shift", v, 8'h3E);
      compare_all();
      @(negedge clk); sclk_in = 1'b1;
      @(negedge clk); wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h80;
      @(negedge clk); wr_en = 1'b0;
      m_edge(1'b1); m_cnt = 4'd0; m_ovf = 1'b0; m_ext = 1'b1;
      rd(2'd2, v); chk("R9 clear beats count", v, 8'h00);
      compare_all();

      // random mix against the reference model
      for (int n = 0; n < 600; n++) begin
         int op;
         op = $urandom_range(0, 9);
         case (op)
            0, 1, 2, 3: toggle();
            4: host_wr(2'd0, 8'($urandom));
            5: begin @(negedge clk); sdi = 1'($urandom); end
            6: host_wr(2'd2, 8'($urandom));
            7: host_wr(2'd1, {4'b0, 4'($urandom)});
            default: ext_drive(!m_ext);
         endcase
         compare_all();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule